// File: doc/BRIEF.md
# Program-Counter / Link-Register Role Swap Unit

This block keeps two physical registers that act as the program counter and the link register. Neither register ever copies its contents into the other. A single swap flag decides which physical register plays which role. It does this by steering the load, increment and active-low output-enable controls of each register. Toggling the flag therefore exchanges the two roles at a clock edge, costs no cycle and moves no data.

The block also sequences two kinds of control transfer. A literal jump starts with a fetch. In that fetch the program-counter role drives the address bus and steps by one, and the fetched word is held in a latch. If the word's top bit is clear, the next machine-cycle strobe does two things at the same edge: it loads the latched word into the link-role register and it toggles the flag. The target then becomes the program counter, and the link register holds the address of the word that followed the jump word. A write whose destination is the program counter uses the same mechanism. The data-bus word goes into the link-role register, and the flag toggles at that same edge. Every action is qualified by the machine-cycle strobe.

Top module: `pclr_swap_unit`

## Requirements
- R1: A synchronous active-high reset clears the swap flag to 0 and both physical registers to zero, and puts the sequencer in the fetch phase.
- R2: With the swap flag at 0, the program-counter output shows the high physical register and the link output shows the low one. With the flag at 1 the two are exchanged.
- R3: The address output always equals the current program-counter role value.
- R4: A strobed fetch (fetch request high, no PC write, fetch phase) advances the program counter by exactly one in that single cycle. The link register and the swap flag are unchanged.
- R5: When the strobe is low, neither physical register, nor the swap flag, nor the sequencer phase changes, whatever the other inputs are.
- R6: A fetched word with bit WIDTH-1 equal to 0 is a literal target. At the next strobe the program counter becomes that word, the link register becomes the jump word's address plus one, and the swap flag toggles.
- R7: A fetched word with bit WIDTH-1 equal to 1 starts no jump. The following strobed fetch simply advances the program counter again.
- R8: A strobed PC write in the fetch phase loads the data-bus word into the link-role register and toggles the flag at the same edge. The new program counter is that word and the new link register is the old program counter. A PC write takes priority over a fetch request in the same cycle.
- R9: In the strobe that completes a literal jump, the fetch request, the PC write and the data bus have no effect on the result.
- R10: A role exchange leaves the physical register that is not loaded holding its value.
- R11: Program-counter increment wraps modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Machine-cycle strobe qualifying every action |
| fetch_req | input | 1 | Request an instruction fetch this cycle |
| pc_wr | input | 1 | Instruction writes the program counter as destination |
| data_in | input | WIDTH | Data bus word (fetched word or PC write value) |
| addr_out | output | WIDTH | Fetch address (program-counter role) |
| pc_out | output | WIDTH | Program-counter role contents |
| lr_out | output | WIDTH | Link-register role contents |
| phys_lo | output | WIDTH | Low physical register contents |
| phys_hi | output | WIDTH | High physical register contents |
| swap_flag | output | 1 | Current role-swap flag |

## Verification
The bench builds the unit with WIDTH set to 8. With that width, the literal flag is bit 7 and a word such as 8'hFF can be written into the program counter. Wraparound of the increment is then one fetch away. The narrow width also lets literal and non-literal words, back-to-back jumps and PC writes that collide with fetch requests all be mixed in a short run. The physical-register outputs are compared against the bench's role model, so the check confirms that an exchange moves no data.

// File: rtl/pclr_pkg.sv
package pclr_pkg;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_LIT   = 1'b1
  } phase_e;

  localparam int unsigned NUM_PHYS = 2;

  // Physical slot holding the program-counter role for a given flag.
  function automatic logic pc_slot(input logic swap);
    return ~swap;
  endfunction

  // Physical slot holding the link role for a given flag.
  function automatic logic lr_slot(input logic swap);
    return swap;
  endfunction

endpackage

// File: rtl/pclr_phys_reg.sv
module pclr_phys_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             inc,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  function automatic logic [WIDTH-1:0] step_addr(input logic [WIDTH-1:0] v);
    return v + WIDTH'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= d;
    else if (inc) q <= step_addr(q);
  end

endmodule

// File: rtl/pclr_role_map.sv
module pclr_role_map
  import pclr_pkg::*;
(
  input  logic                swap,
  input  logic                pc_inc,
  input  logic                lr_load,
  output logic [NUM_PHYS-1:0] ld_en,
  output logic [NUM_PHYS-1:0] inc_en,
  output logic [NUM_PHYS-1:0] pc_oe_n,
  output logic [NUM_PHYS-1:0] lr_oe_n
);

  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_slot
    localparam logic IDX = 1'(i);
    assign ld_en[i]   = lr_load & (lr_slot(swap) == IDX);
    assign inc_en[i]  = pc_inc  & (pc_slot(swap) == IDX);
    assign pc_oe_n[i] = (pc_slot(swap) != IDX);
    assign lr_oe_n[i] = (lr_slot(swap) != IDX);
  end

endmodule

// File: rtl/pclr_seq.sv
module pclr_seq
  import pclr_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             fetch_req,
  input  logic             pc_wr,
  input  logic [WIDTH-1:0] data_in,
  output logic             pc_inc,
  output logic             lr_load,
  output logic [WIDTH-1:0] lr_data,
  output logic             swap_tgl,
  output logic             lit_phase
);

  localparam int unsigned FLAG_BIT = WIDTH - 1;

  phase_e           phase, next_phase;
  logic [WIDTH-1:0] latch_q;
  logic             capture;

  function automatic logic is_literal(input logic [WIDTH-1:0] w);
    return ~w[FLAG_BIT];
  endfunction

  always_comb begin
    pc_inc     = 1'b0;
    lr_load    = 1'b0;
    swap_tgl   = 1'b0;
    capture    = 1'b0;
    lr_data    = data_in;
    next_phase = phase;
    if (cyc_en) begin
      if (phase == PH_FETCH) begin
        if (pc_wr) begin
          lr_load  = 1'b1;
          swap_tgl = 1'b1;
        end else if (fetch_req) begin
          pc_inc  = 1'b1;
          capture = 1'b1;
          if (is_literal(data_in)) next_phase = PH_LIT;
        end
      end else begin
        lr_load    = 1'b1;
        lr_data    = latch_q;
        swap_tgl   = 1'b1;
        next_phase = PH_FETCH;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_FETCH;
      latch_q <= '0;
    end else begin
      phase <= next_phase;
      if (capture) latch_q <= data_in;
    end
  end

  assign lit_phase = (phase == PH_LIT);

endmodule

// File: rtl/pclr_swap_unit.sv
module pclr_swap_unit
  import pclr_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             fetch_req,
  input  logic             pc_wr,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] addr_out,
  output logic [WIDTH-1:0] pc_out,
  output logic [WIDTH-1:0] lr_out,
  output logic [WIDTH-1:0] phys_lo,
  output logic [WIDTH-1:0] phys_hi,
  output logic             swap_flag
);

  logic                pc_inc_ev;
  logic                lr_load_ev;
  logic                swap_tgl_ev;
  logic                lit_phase;
  logic [WIDTH-1:0]    lr_data;
  logic [NUM_PHYS-1:0] ld_en, inc_en, pc_oe_n, lr_oe_n;
  logic [WIDTH-1:0]    q [NUM_PHYS];

  pclr_seq #(.WIDTH(WIDTH)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .cyc_en    (cyc_en),
    .fetch_req (fetch_req),
    .pc_wr     (pc_wr),
    .data_in   (data_in),
    .pc_inc    (pc_inc_ev),
    .lr_load   (lr_load_ev),
    .lr_data   (lr_data),
    .swap_tgl  (swap_tgl_ev),
    .lit_phase (lit_phase)
  );

  always_ff @(posedge clk) begin
    if (rst)              swap_flag <= 1'b0;
    else if (swap_tgl_ev) swap_flag <= ~swap_flag;
  end

  pclr_role_map map_i (
    .swap    (swap_flag),
    .pc_inc  (pc_inc_ev),
    .lr_load (lr_load_ev),
    .ld_en   (ld_en),
    .inc_en  (inc_en),
    .pc_oe_n (pc_oe_n),
    .lr_oe_n (lr_oe_n)
  );

  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_reg
    pclr_phys_reg #(.WIDTH(WIDTH)) reg_i (
      .clk (clk),
      .rst (rst),
      .ld  (ld_en[i]),
      .inc (inc_en[i]),
      .d   (lr_data),
      .q   (q[i])
    );
  end

  always_comb begin
    pc_out = '0;
    lr_out = '0;
    for (int i = 0; i < NUM_PHYS; i++) begin
      if (!pc_oe_n[i]) pc_out = pc_out | q[i];
      if (!lr_oe_n[i]) lr_out = lr_out | q[i];
    end
  end

  assign addr_out = pc_out;
  assign phys_lo  = q[0];
  assign phys_hi  = q[1];

endmodule

// File: rtl/pclr_swap_chk.sv
module pclr_swap_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_en,
  input logic             swap_flag,
  input logic [WIDTH-1:0] addr_out,
  input logic [WIDTH-1:0] pc_out,
  input logic [WIDTH-1:0] lr_out,
  input logic [WIDTH-1:0] phys_lo,
  input logic [WIDTH-1:0] phys_hi,
  input logic             pc_inc_ev,
  input logic             swap_tgl_ev,
  input logic             lit_phase
);

  assert_role_map_R2: assert property (@(posedge clk) disable iff (rst)
    swap_flag ? (pc_out == phys_lo && lr_out == phys_hi)
              : (pc_out == phys_hi && lr_out == phys_lo));

  assert_addr_is_pc_R3: assert property (@(posedge clk) disable iff (rst)
    addr_out == pc_out);

  assert_fetch_step_R4: assert property (@(posedge clk) disable iff (rst)
    pc_inc_ev |=> (pc_out == $past(pc_out) + WIDTH'(1)) && $stable(swap_flag)
                  && $stable(lr_out));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> $stable(phys_lo) && $stable(phys_hi) && $stable(swap_flag));

  assert_literal_swap_R6: assert property (@(posedge clk) disable iff (rst)
    (lit_phase && cyc_en) |=> (swap_flag != $past(swap_flag))
                              && (lr_out == $past(pc_out)));

  assert_no_copy_R10: assert property (@(posedge clk) disable iff (rst)
    (swap_tgl_ev && !swap_flag) |=> $stable(phys_hi));

endmodule

bind pclr_swap_unit pclr_swap_chk #(.WIDTH(WIDTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cyc_en      (cyc_en),
  .swap_flag   (swap_flag),
  .addr_out    (addr_out),
  .pc_out      (pc_out),
  .lr_out      (lr_out),
  .phys_lo     (phys_lo),
  .phys_hi     (phys_hi),
  .pc_inc_ev   (pc_inc_ev),
  .swap_tgl_ev (swap_tgl_ev),
  .lit_phase   (lit_phase)
);

// File: tb/pclr_swap_unit_tb_top.sv
module pclr_swap_unit_tb_top;

  localparam int W      = 8;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cyc_en = 1'b0, fetch_req = 1'b0, pc_wr = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] addr_out, pc_out, lr_out, phys_lo, phys_hi;
  logic         swap_flag;

  int    n_total = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  // behavioural reference: logical roles plus flag
  logic [W-1:0] m_pc = '0, m_lr = '0, m_latch = '0;
  bit           m_swap = 0;
  bit           m_lit = 0;

  always #(CLK_NS/2) clk = ~clk;

  pclr_swap_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .fetch_req(fetch_req),
    .pc_wr(pc_wr), .data_in(data_in), .addr_out(addr_out),
    .pc_out(pc_out), .lr_out(lr_out), .phys_lo(phys_lo),
    .phys_hi(phys_hi), .swap_flag(swap_flag)
  );

  task automatic chk(input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp, input string what);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge(input bit r, input bit c, input bit fe,
                            input bit wr, input logic [W-1:0] d);
    logic [W-1:0] old_pc;
    old_pc = m_pc;
    if (r) begin
      m_pc = '0; m_lr = '0; m_latch = '0; m_swap = 0; m_lit = 0;
    end else if (c) begin
      if (m_lit) begin
        m_pc = m_latch; m_lr = old_pc; m_swap = !m_swap; m_lit = 0;
      end else if (wr) begin
        m_pc = d; m_lr = old_pc; m_swap = !m_swap;
      end else if (fe) begin
        m_pc = (m_pc + 1) % (1 << W);
        m_latch = d;
        m_lit = (d < (1 << (W-1)));
      end
    end
  endtask

  task automatic compare_all();
    chk(cur_req, pc_out, m_pc, "pc_out");
    chk(cur_req, lr_out, m_lr, "lr_out");
    chk(cur_req, {{(W-1){1'b0}}, swap_flag}, {{(W-1){1'b0}}, m_swap}, "swap_flag");
    chk("R3", addr_out, m_pc, "addr_out");
    chk("R2", phys_hi, m_swap ? m_lr : m_pc, "phys_hi");
    chk("R2", phys_lo, m_swap ? m_pc : m_lr, "phys_lo");
  endtask

  task automatic step(input bit r, input bit c, input bit fe,
                      input bit wr, input logic [W-1:0] d);
    rst = r; cyc_en = c; fetch_req = fe; pc_wr = wr; data_in = d;
    @(posedge clk);
    model_edge(r, c, fe, wr, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  endtask

  initial begin
    logic [W-1:0] keep;
    @(negedge clk);
    cur_req = "R1";
    step(1, 1, 1, 1, 8'h5A);
    step(1, 0, 0, 0, 8'h00);

    cur_req = "R4";
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, 8'h80 + 8'(i));

    cur_req = "R7";
    step(0, 1, 1, 0, 8'hFF);
    step(0, 1, 1, 0, 8'hC3);

    cur_req = "R5";
    step(0, 0, 1, 0, 8'h11);
    step(0, 0, 0, 1, 8'h22);
    step(0, 0, 1, 1, 8'h33);

    cur_req = "R8";
    keep = phys_hi;
    step(0, 1, 0, 1, 8'h40);
    chk("R10", phys_hi, keep, "untouched phys_hi after exchange");
    keep = phys_lo;
    step(0, 1, 1, 1, 8'hA5);
    chk("R10", phys_lo, keep, "untouched phys_lo after exchange");
    step(0, 1, 1, 0, 8'h81);

    cur_req = "R6";
    step(0, 1, 1, 0, 8'h3C);
    step(0, 1, 0, 0, 8'h00);
    step(0, 1, 1, 0, 8'h92);
    step(0, 1, 1, 0, 8'h17);
    step(0, 0, 0, 0, 8'h00);
    step(0, 1, 0, 0, 8'h00);

    cur_req = "R9";
    step(0, 1, 1, 0, 8'h05);
    step(0, 1, 1, 1, 8'hEE);
    step(0, 1, 1, 0, 8'h00);
    step(0, 1, 0, 1, 8'h7F);

    cur_req = "R11";
    step(0, 1, 0, 1, 8'hFF);
    step(0, 1, 1, 0, 8'h90);
    chk("R11", pc_out, 8'h00, "wrapped pc");
    step(0, 1, 1, 0, 8'hB0);

    cur_req = "R1";
    step(1, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 8'h00);
    finish_run();
  end

  initial begin
    #(CLK_NS * 20000);
    n_total++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule